// File: doc/BRIEF.md
# Keyed-Clear Watchdog Timer

This block is a memory-mapped watchdog for a system-on-chip. A fixed divide-by-32 prescaler feeds a period counter. The counter expires after 2^ps prescaled ticks, where ps is a 5-bit period exponent taken from configuration pins at reset. While the run bit is set, software must keep the counter from expiring. The only way to restart the period is to write a 16-bit key into the upper half-word of the control register. If software fails to do this, the block emits a one-cycle reset request and latches a timeout flag in a separate status register. The system reset generator that consumes the request is outside the block.

The bus has six word addresses: a control register, a status register, and a clear alias and a set alias for each of them. Software can therefore change single bits without a read-modify-write. The period exponent, the clock-source code and the windowed-clear indicator are read-only copies of the configuration pins. In the cycle right after the run bit drops, the block ignores any bus access.

Top module: `keyed_watchdog`

## Requirements
- R1: Synchronous reset clears the run bit (control bit 15), the timeout flag (status bit 4) and `rst_req`. It also loads control bits 12:8 from `cfg_ps`, bits 7:6 from `cfg_clksel` and bit 0 from `cfg_window`. All other control and status bits read as 0.
- R2: If the run bit rises at clock edge E, `rst_req` is first high in the cycle after edge E + 32·2^ps.
- R3: `rst_req` stays high for one cycle only. Counting restarts from zero, so while the run bit stays set the next pulse comes 32·2^ps cycles after the previous one.
- R4: The timeout flag is set on the edge after the `rst_req` pulse and holds until software clears it.
- R5: A write to word 0 with `bus_be` = 4'b1100 and `bus_wdata[31:16]` = 16'h5743 clears the prescaler and the counter. The next expiry then falls 32·2^ps cycles after that write's edge.
- R6: A key write with any other upper half-word value, or the correct key written with `bus_be` = 4'b1111, leaves the expiry time unchanged.
- R7: The counter advances only while the run bit is 1. Clearing the run bit zeroes the prescaler and the counter, so the next run starts a full period, and no `rst_req` occurs while the bit is 0.
- R8: The word map is 0 = control, 1 = control-clear, 2 = control-set, 4 = status, 5 = status-clear, 6 = status-set. A write to an alias clears or sets exactly the bits written as 1 (bit 15 needs `bus_be[1]`, bit 4 needs `bus_be[0]`). Bits written as 0 have no effect. A direct write to word 0 or word 4 loads the bit.
- R9: Writes never change control bits 12:8, 7:6 or 0.
- R10: Any bus access in the cycle right after the edge that cleared the run bit is ignored.
- R11: Read data appears on `bus_rdata` one edge after the read is presented. Reads of an alias return the register it aliases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_ps | input | 5 | Period exponent, sampled at reset |
| cfg_clksel | input | 2 | Clock-source code, sampled at reset |
| cfg_window | input | 1 | Windowed-clear indicator, sampled at reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word address |
| bus_be | input | 4 | Byte enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| rst_req | output | 1 | One-cycle reset request on expiry |

## Verification
Each result has a fixed latency from its stimulus. The reset request appears exactly 32·2^ps edges after the edge that sets the run bit or accepts a key. The timeout flag follows the pulse by one edge, and read data follows the read by one edge. The bench keeps a free-running count of rising edges and drives and samples only at falling edges. It records the edge count when a write completes and compares the count at the first sampled pulse against that value plus the expected period, so a single-cycle skew is detected. The quiet cycle is hit with two back-to-back accesses whose second lands on the edge right after the run bit drops.

// File: rtl/keyed_wdog_pkg.sv
package keyed_wdog_pkg;

  typedef enum logic [2:0] {
    RG_CTRL     = 3'd0,
    RG_CTRL_CLR = 3'd1,
    RG_CTRL_SET = 3'd2,
    RG_STAT     = 3'd4,
    RG_STAT_CLR = 3'd5,
    RG_STAT_SET = 3'd6
  } reg_sel_e;

  localparam int RUN_BIT = 15;
  localparam int PS_LSB  = 8;
  localparam int CS_LSB  = 6;
  localparam int WIN_BIT = 0;
  localparam int TMO_BIT = 4;

endpackage

// File: rtl/keyed_wdog_regs.sv
module keyed_wdog_regs
  import keyed_wdog_pkg::*;
#(
  parameter int          ADDR_W = 3,
  parameter int          PS_W   = 5,
  parameter int          CS_W   = 2,
  parameter logic [15:0] KEY    = 16'h5743,
  parameter bit          RUN_RST = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PS_W-1:0]   cfg_ps,
  input  logic [CS_W-1:0]   cfg_clksel,
  input  logic              cfg_window,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              expire,
  output logic              run_o,
  output logic [PS_W-1:0]   ps_o,
  output logic              restart_o,
  output logic              flag_o
);

  logic            run_q, run_n;
  logic            flag_q, flag_n;
  logic            quiet_q;
  logic [PS_W-1:0] ps_q;
  logic [CS_W-1:0] cs_q;
  logic            win_q;
  logic            in_map, access, wr_acc;
  reg_sel_e        sel;
  logic [31:0]     ctrl_word, stat_word;

  assign in_map = (bus_addr >> 3) == '0;
  assign sel    = reg_sel_e'(bus_addr[2:0]);
  assign access = bus_sel && in_map && !quiet_q;
  assign wr_acc = access && bus_wr;

  wire unused_wbits = ^{bus_wdata[14:5], bus_wdata[3:0]};

  // run bit next state
  always_comb begin
    run_n = run_q;
    if (wr_acc && bus_be[1]) begin
      case (sel)
        RG_CTRL:     run_n = bus_wdata[RUN_BIT];
        RG_CTRL_CLR: if (bus_wdata[RUN_BIT]) run_n = 1'b0;
        RG_CTRL_SET: if (bus_wdata[RUN_BIT]) run_n = 1'b1;
        default:     run_n = run_q;
      endcase
    end
  end

  // timeout flag next state; expiry wins over a same-cycle clear
  always_comb begin
    flag_n = flag_q;
    if (wr_acc && bus_be[0]) begin
      case (sel)
        RG_STAT:     flag_n = bus_wdata[TMO_BIT];
        RG_STAT_CLR: if (bus_wdata[TMO_BIT]) flag_n = 1'b0;
        RG_STAT_SET: if (bus_wdata[TMO_BIT]) flag_n = 1'b1;
        default:     flag_n = flag_q;
      endcase
    end
    if (expire) flag_n = 1'b1;
  end

  assign restart_o = wr_acc && (sel == RG_CTRL) && (bus_be == 4'b1100)
                     && (bus_wdata[31:16] == KEY);

  always_comb begin
    ctrl_word                    = '0;
    ctrl_word[RUN_BIT]           = run_q;
    ctrl_word[PS_LSB +: PS_W]    = ps_q;
    ctrl_word[CS_LSB +: CS_W]    = cs_q;
    ctrl_word[WIN_BIT]           = win_q;
    stat_word                    = '0;
    stat_word[TMO_BIT]           = flag_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q     <= RUN_RST;
      flag_q    <= 1'b0;
      quiet_q   <= 1'b0;
      ps_q      <= cfg_ps;
      cs_q      <= cfg_clksel;
      win_q     <= cfg_window;
      bus_rdata <= '0;
    end else begin
      run_q     <= run_n;
      flag_q    <= flag_n;
      quiet_q   <= run_q && !run_n;
      bus_rdata <= (access && !bus_wr) ? (bus_addr[2] ? stat_word : ctrl_word) : '0;
    end
  end

  assign run_o  = run_q;
  assign ps_o   = ps_q;
  assign flag_o = flag_q;

endmodule

// File: rtl/keyed_wdog_timer.sv
module keyed_wdog_timer #(
  parameter int PRE_W = 5,
  parameter int PS_W  = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic            restart,
  input  logic [PS_W-1:0] ps,
  output logic            expire_o
);

  localparam int CNT_W = 1 << PS_W;

  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] cnt_q, term;
  logic             tick;

  assign tick = &pre_q;
  assign term = (CNT_W'(1) << ps) - CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst || !run || restart) begin
      pre_q    <= '0;
      cnt_q    <= '0;
      expire_o <= 1'b0;
    end else begin
      pre_q    <= pre_q + PRE_W'(1);
      expire_o <= 1'b0;
      if (tick) begin
        if (cnt_q == term) begin
          cnt_q    <= '0;
          expire_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog #(
  parameter int          ADDR_W  = 3,
  parameter int          PRE_W   = 5,
  parameter int          PS_W    = 5,
  parameter int          CS_W    = 2,
  parameter logic [15:0] KEY     = 16'h5743,
  parameter bit          RUN_RST = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PS_W-1:0]   cfg_ps,
  input  logic [CS_W-1:0]   cfg_clksel,
  input  logic              cfg_window,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              rst_req
);

  logic            ctrl_run;
  logic            tmo_flag;
  logic            restart;
  logic [PS_W-1:0] ps_q;

  keyed_wdog_regs #(
    .ADDR_W(ADDR_W), .PS_W(PS_W), .CS_W(CS_W), .KEY(KEY), .RUN_RST(RUN_RST)
  ) u_regs (
    .clk(clk), .rst(rst),
    .cfg_ps(cfg_ps), .cfg_clksel(cfg_clksel), .cfg_window(cfg_window),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .expire(rst_req), .run_o(ctrl_run), .ps_o(ps_q),
    .restart_o(restart), .flag_o(tmo_flag)
  );

  keyed_wdog_timer #(.PRE_W(PRE_W), .PS_W(PS_W)) u_timer (
    .clk(clk), .rst(rst), .run(ctrl_run), .restart(restart),
    .ps(ps_q), .expire_o(rst_req)
  );

endmodule

// File: rtl/keyed_wdog_chk.sv
module keyed_wdog_chk #(
  parameter int PS_W = 5
) (
  input logic            clk,
  input logic            rst,
  input logic            run,
  input logic            rst_req,
  input logic            flag,
  input logic [PS_W-1:0] ps
);

  // R3
  pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> !rst_req);

  // R4
  flag_follows_chk: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> flag);

  // R7
  idle_silent_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> !rst_req);

  // R9
  ps_fixed_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(ps));

  // R10
  quiet_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(run) |=> !run);

endmodule

bind keyed_watchdog keyed_wdog_chk #(.PS_W(PS_W)) u_chk (
  .clk(clk), .rst(rst), .run(ctrl_run), .rst_req(rst_req),
  .flag(tmo_flag), .ps(ps_q)
);

// File: tb/keyed_watchdog_tb.sv
module keyed_watchdog_tb;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  cfg_ps = 5'd2;
  logic [1:0]  cfg_clksel = 2'd2;
  logic        cfg_window = 1'b1;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rst_req;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;

  keyed_watchdog u_dut (
    .clk(clk), .rst(rst), .cfg_ps(cfg_ps), .cfg_clksel(cfg_clksel),
    .cfg_window(cfg_window), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .rst_req(rst_req)
  );

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle_bus();
    bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_be = '0; bus_wdata = '0;
  endtask

  task automatic bwrite(input logic [2:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
    @(negedge clk);
    idle_bus();
  endtask

  task automatic bread(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_be = 4'hF;
    @(negedge clk);
    d = bus_rdata;
    idle_bus();
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_fire(input int limit, output int at);
    at = -1;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (rst_req) begin
        at = cyc;
        break;
      end
    end
  endtask

  task automatic do_reset(input logic [4:0] ps, input logic [1:0] cs, input logic win);
    @(negedge clk);
    idle_bus();
    cfg_ps = ps; cfg_clksel = cs; cfg_window = win;
    rst = 1'b1;
    wait_n(3);
    rst = 1'b0;
  endtask

  // R1 R11: state after reset
  task automatic t_reset();
    logic [31:0] d;
    do_reset(5'd2, 2'd2, 1'b1);
    chk(rst_req == 1'b0, "R1 rst_req after reset", rst_req, 0);
    bread(3'd0, d);
    chk(d == 32'h0000_0281, "R1 R11 control after reset", d, 32'h281);
    bread(3'd4, d);
    chk(d == 32'h0, "R1 status after reset", d, 0);
  endtask

  // R2 R3 R4 R8: expiry, periodic pulse, flag
  task automatic t_expiry();
    int t0, f1, f2;
    logic [31:0] d;
    bwrite(3'd2, 4'b0010, 32'h0000_8000);
    t0 = cyc;
    wait_fire(400, f1);
    chk(f1 == t0 + 128, "R2 first expiry", f1, t0 + 128);
    @(negedge clk);
    chk(rst_req == 1'b0, "R3 pulse width", rst_req, 0);
    bread(3'd4, d);
    chk(d == 32'h10, "R4 flag set", d, 32'h10);
    wait_fire(400, f2);
    chk(f2 == f1 + 128, "R3 second expiry", f2, f1 + 128);
    bread(3'd5, d);
    chk(d == 32'h10, "R11 alias read", d, 32'h10);
    bwrite(3'd5, 4'b0001, 32'h10);
    bread(3'd4, d);
    chk(d == 32'h0, "R8 status clear alias", d, 0);
    bwrite(3'd1, 4'b0010, 32'h8000);
  endtask

  // R5: key restarts the period
  task automatic t_key();
    int tk, f;
    bwrite(3'd2, 4'b0010, 32'h8000);
    wait_n(100);
    bwrite(3'd0, 4'b1100, 32'h5743_0000);
    tk = cyc;
    wait_fire(400, f);
    chk(f == tk + 128, "R5 key restart", f, tk + 128);
    bwrite(3'd1, 4'b0010, 32'h8000);
  endtask

  // R6: wrong key and full-word key ignored
  task automatic t_badkey();
    int t0, f;
    bwrite(3'd2, 4'b0010, 32'h8000);
    t0 = cyc;
    wait_n(50);
    bwrite(3'd0, 4'b1100, 32'h1234_0000);
    bwrite(3'd0, 4'b1111, 32'h5743_8000);
    wait_fire(400, f);
    chk(f == t0 + 128, "R6 bad keys ignored", f, t0 + 128);
    bwrite(3'd1, 4'b0010, 32'h8000);
  endtask

  // R9 R8: read-only fields, zero bits in aliases
  task automatic t_fields();
    logic [31:0] d;
    bwrite(3'd5, 4'b0001, 32'h10);
    bwrite(3'd0, 4'b1111, 32'h0000_1FC1);
    bread(3'd0, d);
    chk(d == 32'h281, "R9 read-only fields", d, 32'h281);
    bwrite(3'd2, 4'b1111, 32'h0);
    bread(3'd0, d);
    chk(d == 32'h281, "R8 zero set alias", d, 32'h281);
    bwrite(3'd6, 4'b0001, 32'h10);
    bread(3'd4, d);
    chk(d == 32'h10, "R8 status set alias", d, 32'h10);
    bwrite(3'd5, 4'b0001, 32'h0);
    bread(3'd4, d);
    chk(d == 32'h10, "R8 zero clear alias", d, 32'h10);
    bwrite(3'd5, 4'b0001, 32'h10);
  endtask

  // R10 R7: quiet cycle, no pulse while stopped
  task automatic t_quiet();
    logic [31:0] d;
    int seen;
    bwrite(3'd2, 4'b0010, 32'h8000);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 3'd1; bus_be = 4'b0010; bus_wdata = 32'h8000;
    @(negedge clk);
    bus_addr = 3'd2;
    @(negedge clk);
    idle_bus();
    bread(3'd0, d);
    chk(d == 32'h281, "R10 quiet cycle access ignored", d, 32'h281);
    seen = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (rst_req) seen++;
    end
    chk(seen == 0, "R7 no pulse while stopped", seen, 0);
  endtask

  // R7: stopping restarts the period
  task automatic t_stop_restart();
    int t1, f;
    bwrite(3'd2, 4'b0010, 32'h8000);
    wait_n(100);
    bwrite(3'd1, 4'b0010, 32'h8000);
    wait_n(5);
    bwrite(3'd0, 4'b0010, 32'h8000);
    t1 = cyc;
    wait_fire(400, f);
    chk(f == t1 + 128, "R7 full period after stop", f, t1 + 128);
    bwrite(3'd1, 4'b0010, 32'h8000);
  endtask

  // R1 R2: shortest period
  task automatic t_ps0();
    logic [31:0] d;
    int t0, f;
    do_reset(5'd0, 2'd1, 1'b0);
    bread(3'd0, d);
    chk(d == 32'h0000_0040, "R1 control with other pins", d, 32'h40);
    bwrite(3'd2, 4'b0010, 32'h8000);
    t0 = cyc;
    wait_fire(100, f);
    chk(f == t0 + 32, "R2 period with ps 0", f, t0 + 32);
    bwrite(3'd1, 4'b0010, 32'h8000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_expiry();
    t_key();
    t_badkey();
    t_fields();
    t_quiet();
    t_stop_restart();
    t_ps0();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule